// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic core of a small 8-bit datapath. It holds an accumulator and a temporary operand register. On an execute strobe it combines the two registers with one of five operations: add, subtract, AND, OR or XOR. It writes the result back into the accumulator and updates an 8-bit status byte.

The status byte carries five condition flags: sign, zero, nibble carry (for decimal adjust), even parity and carry. On subtraction the carry flag means borrow. The surrounding logic loads operands through a shared data input and the two load strobes, then fires the execute strobe with an opcode. The accumulator and the status byte are always visible on the outputs.

Top module: `acc_alu_unit`

## Requirements
- R1: While rst_ni is low, acc_o reads 8'h00 and flags_o reads 8'h02, and this state persists after reset release until a strobe arrives.
- R2: A rising clock edge with acc_load_i high (and no valid execute) copies data_i into the accumulator and leaves flags_o unchanged. A rising edge with tmp_load_i high copies data_i into the temporary register and leaves acc_o and flags_o unchanged.
- R3: With exec_i high, opcode 3'd0 stores (acc + tmp) mod 256 and opcode 3'd1 stores (acc - tmp) mod 256 into the accumulator.
- R4: With exec_i high, opcode 3'd2 stores acc AND tmp, 3'd3 stores acc OR tmp and 3'd4 stores acc XOR tmp.
- R5: With exec_i high, opcodes 3'd5 to 3'd7 change neither acc_o nor flags_o, and an accompanying acc_load_i is honoured as in R2.
- R6: flags_o bit 5 and bit 3 always read 0, and bit 1 always reads 1.
- R7: After an operation, flags_o bit 7 (sign) equals bit 7 of the result, and flags_o bit 6 (zero) is 1 exactly when the result is 8'h00.
- R8: After an operation, flags_o bit 2 (parity) is 1 exactly when the result has an even number of 1 bits.
- R9: flags_o bit 4 (nibble carry) is set on add when a carry leaves bit 3. On subtract it is set when the low nibble of acc is below that of tmp. AND sets it, and OR and XOR clear it.
- R10: flags_o bit 0 (carry) is set on add when a carry leaves bit 7. On subtract it is set when acc is below tmp (a borrow). All three logic operations clear it.
- R11: A valid execute overrides acc_load_i in the same cycle. A tmp_load_i in the same cycle as an execute takes effect afterwards, so the operation uses the previous tmp value.
- R12: Every register change is visible on acc_o and flags_o right after the clock edge that samples the strobe, one cycle of latency, with no combinational path from the inputs to the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Operand data for both load strobes |
| acc_load_i | input | 1 | Load the accumulator from data_i |
| tmp_load_i | input | 1 | Load the temporary register from data_i |
| exec_i | input | 1 | Execute the operation selected by op_i |
| op_i | input | 3 | Operation code: 0 add, 1 sub, 2 and, 3 or, 4 xor |
| acc_o | output | 8 | Accumulator contents |
| flags_o | output | 8 | Status byte {S, Z, 0, AC, 0, P, 1, CY} |

## Verification
Each strobe takes effect at the next rising edge. The accumulator, temporary register and status byte all settle after that edge, so every result is due exactly one cycle after its stimulus is applied. The bench drives inputs on the falling edge and lets one rising edge pass. It compares acc_o and flags_o against its own model on the following falling edge, before it applies the next stimulus. Tmp-only loads, ignored opcodes and same-cycle conflicts are checked the same way, because their effect or non-effect shows at the outputs in that same one-cycle window.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4
  } alu_op_e;

  localparam int unsigned FLAG_W   = 8;
  localparam int unsigned FB_SIGN  = 7;
  localparam int unsigned FB_ZERO  = 6;
  localparam int unsigned FB_HALF  = 4;
  localparam int unsigned FB_PAR   = 2;
  localparam int unsigned FB_CARRY = 0;

  localparam logic [FLAG_W-1:0] FLAGS_RST = 8'h02;

  function automatic logic op_known(input logic [2:0] op);
    return op <= 3'd4;
  endfunction

endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         hcout_o
);
  localparam int unsigned HALF = W / 2;

  logic [W:0]   c;
  logic [W-1:0] b_eff;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign c[0]  = sub_i;

  for (genvar i = 0; i < W; i++) begin : g_rip
    assign sum_o[i] = a_i[i] ^ b_eff[i] ^ c[i];
    assign c[i+1]   = (a_i[i] & b_eff[i]) | (c[i] & (a_i[i] ^ b_eff[i]));
  end

  assign cout_o  = c[W];
  assign hcout_o = c[HALF];
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   op_i,
  output logic [W-1:0] res_o
);
  import acc_alu_pkg::*;

  always_comb begin
    unique case (op_i)
      3'(OP_AND): res_o = a_i & b_i;
      3'(OP_OR):  res_o = a_i | b_i;
      default:    res_o = a_i ^ b_i;
    endcase
  end
endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]                  res_i,
  input  logic [2:0]                    op_i,
  input  logic                          cout_i,
  input  logic                          hcout_i,
  output logic [acc_alu_pkg::FLAG_W-1:0] flags_o
);
  import acc_alu_pkg::*;

  logic f_s, f_z, f_p, f_ac, f_cy;

  assign f_s = res_i[W-1];
  assign f_z = ~|res_i;
  assign f_p = ~^res_i;

  always_comb begin
    unique case (op_i)
      3'(OP_ADD): begin f_ac = hcout_i;  f_cy = cout_i;  end
      3'(OP_SUB): begin f_ac = ~hcout_i; f_cy = ~cout_i; end // carry inverted into borrow
      3'(OP_AND): begin f_ac = 1'b1;     f_cy = 1'b0;    end
      default:    begin f_ac = 1'b0;     f_cy = 1'b0;    end
    endcase
  end

  always_comb begin
    flags_o           = FLAGS_RST;
    flags_o[FB_SIGN]  = f_s;
    flags_o[FB_ZERO]  = f_z;
    flags_o[FB_HALF]  = f_ac;
    flags_o[FB_PAR]   = f_p;
    flags_o[FB_CARRY] = f_cy;
  end
endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              acc_load_i,
  input  logic              tmp_load_i,
  input  logic              exec_i,
  input  logic [2:0]        op_i,
  output logic [DATA_W-1:0] acc_o,
  output logic [7:0]        flags_o
);
  import acc_alu_pkg::*;

  logic [DATA_W-1:0] acc_q, tmp_q;
  logic [FLAG_W-1:0] flags_q;

  logic [DATA_W-1:0] sum, lres, res;
  logic              cout, hcout;
  logic [FLAG_W-1:0] flags_d;
  logic              is_arith, do_exec;

  assign is_arith = (op_i == 3'(OP_ADD)) || (op_i == 3'(OP_SUB));
  assign do_exec  = exec_i && op_known(op_i);

  acc_alu_arith #(.W(DATA_W)) u_arith (
    .a_i    (acc_q),
    .b_i    (tmp_q),
    .sub_i  (op_i == 3'(OP_SUB)),
    .sum_o  (sum),
    .cout_o (cout),
    .hcout_o(hcout)
  );

  acc_alu_logic #(.W(DATA_W)) u_logic (
    .a_i  (acc_q),
    .b_i  (tmp_q),
    .op_i (op_i),
    .res_o(lres)
  );

  assign res = is_arith ? sum : lres;

  acc_alu_flags #(.W(DATA_W)) u_flags (
    .res_i  (res),
    .op_i   (op_i),
    .cout_i (cout),
    .hcout_i(hcout),
    .flags_o(flags_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      flags_q <= FLAGS_RST;
    end else if (do_exec) begin
      acc_q   <= res;
      flags_q <= flags_d;
    end else if (acc_load_i) begin
      acc_q   <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         tmp_q <= '0;
    else if (tmp_load_i) tmp_q <= data_i;
  end

  assign acc_o   = acc_q;
  assign flags_o = flags_q;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] data_i,
  input logic       acc_load_i,
  input logic       tmp_load_i,
  input logic       exec_i,
  input logic [2:0] op_i,
  input logic [7:0] acc_o,
  input logic [7:0] flags_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  logic ran;
  assign ran = exec_i && (op_i <= 3'd4);

  AST_FIXED_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (flags_o[5] == 1'b0 && flags_o[3] == 1'b0 && flags_o[1] == 1'b1)); // R6

  AST_SIGN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ran |=> (flags_o[7] == acc_o[7] && flags_o[6] == (acc_o == 8'h00))); // R7

  AST_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ran |=> (flags_o[2] == ~^acc_o)); // R8

  AST_LOGIC_CY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && op_i >= 3'd2 && op_i <= 3'd4) |=> (flags_o[0] == 1'b0)); // R10

  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !ran) |=> $stable(flags_o)); // R5

  AST_LOAD_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && acc_load_i && !ran) |=> (acc_o == $past(data_i))); // R2

  AST_TMP_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !acc_load_i && !ran) |=> $stable(acc_o)); // R11
endmodule

bind acc_alu_unit acc_alu_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .data_i    (data_i),
  .acc_load_i(acc_load_i),
  .tmp_load_i(tmp_load_i),
  .exec_i    (exec_i),
  .op_i      (op_i),
  .acc_o     (acc_o),
  .flags_o   (flags_o)
);

// File: tb/acc_alu_unit_bench.sv
module acc_alu_unit_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] data_i = '0;
  logic       acc_load_i = 1'b0;
  logic       tmp_load_i = 1'b0;
  logic       exec_i = 1'b0;
  logic [2:0] op_i = '0;
  logic [7:0] acc_o, flags_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] m_acc, m_tmp, m_flg;

  always #4 clk_i = ~clk_i;

  acc_alu_unit u_acc_alu_unit (
    .clk_i, .rst_ni, .data_i, .acc_load_i, .tmp_load_i, .exec_i, .op_i, .acc_o, .flags_o
  );

  function automatic logic [15:0] ref_op(input logic [2:0] op, input logic [7:0] a, input logic [7:0] t);
    logic [8:0] wide;
    logic [7:0] r;
    logic ac, cy;
    case (op)
      3'd0: begin wide = {1'b0, a} + {1'b0, t}; r = wide[7:0]; cy = wide[8];
                  ac = ({1'b0, a[3:0]} + {1'b0, t[3:0]}) > 5'd15; end
      3'd1: begin r = a - t; cy = a < t; ac = a[3:0] < t[3:0]; end
      3'd2: begin r = a & t; cy = 1'b0; ac = 1'b1; end
      3'd3: begin r = a | t; cy = 1'b0; ac = 1'b0; end
      default: begin r = a ^ t; cy = 1'b0; ac = 1'b0; end
    endcase
    return {r, r[7], (r == 8'h00), 1'b0, ac, 1'b0, ~^r, 1'b1, cy};
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s acc/flags actual %h/%h expected %h/%h", tag, got[15:8], got[7:0], exp[15:8], exp[7:0]);
    end
  endtask

  // apply one cycle of stimulus, update model, compare after the edge
  task automatic step(input string tag, input logic al, input logic tl, input logic ex,
                      input logic [2:0] op, input logic [7:0] d);
    logic [15:0] r;
    @(negedge clk_i);
    acc_load_i = al; tmp_load_i = tl; exec_i = ex; op_i = op; data_i = d;
    if (ex && op <= 3'd4) begin
      r = ref_op(op, m_acc, m_tmp);
      m_acc = r[15:8]; m_flg = r[7:0];
    end else if (al) m_acc = d;
    if (tl) m_tmp = d;
    @(posedge clk_i);
    @(negedge clk_i);
    acc_load_i = 1'b0; tmp_load_i = 1'b0; exec_i = 1'b0;
    check(tag, {acc_o, flags_o}, {m_acc, m_flg});
  endtask

  task automatic run_op(input string tag, input logic [7:0] a, input logic [7:0] t, input logic [2:0] op);
    step("R2", 1'b1, 1'b0, 1'b0, 3'd0, a);
    step("R2", 1'b0, 1'b1, 1'b0, 3'd0, t);
    step(tag, 1'b0, 1'b0, 1'b1, op, 8'h00);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    void'($urandom(32'd7177));
    m_acc = 8'h00; m_tmp = 8'h00; m_flg = 8'h02;
    repeat (3) @(negedge clk_i);
    check("R1", {acc_o, flags_o}, 16'h0002);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", {acc_o, flags_o}, 16'h0002);

    run_op("R9",  8'h0F, 8'h01, 3'd0);   // nibble carry on add
    run_op("R10", 8'hFF, 8'h01, 3'd0);   // carry out, zero result
    run_op("R10", 8'h00, 8'h01, 3'd1);   // borrow
    run_op("R7",  8'h5A, 8'h5A, 3'd1);   // equal subtract gives zero
    run_op("R9",  8'h30, 8'h05, 3'd1);   // nibble borrow only
    run_op("R4",  8'hF0, 8'h0F, 3'd2);   // and: zero, AC set
    run_op("R4",  8'hF0, 8'h0F, 3'd3);
    run_op("R8",  8'hA5, 8'h01, 3'd4);
    run_op("R3",  8'h7F, 8'h01, 3'd0);   // sign from overflow into bit 7

    // R5: unknown opcodes are ignored
    step("R5", 1'b0, 1'b0, 1'b1, 3'd5, 8'h00);
    step("R5", 1'b0, 1'b0, 1'b1, 3'd7, 8'h00);
    step("R5", 1'b1, 1'b0, 1'b1, 3'd6, 8'h3C);
    // R2: tmp-only load leaves acc and flags
    step("R2", 1'b0, 1'b1, 1'b0, 3'd0, 8'h11);
    // R11: exec beats acc load, exec uses old tmp
    step("R11", 1'b1, 1'b1, 1'b1, 3'd0, 8'hEE);
    step("R11", 1'b0, 1'b0, 1'b1, 3'd4, 8'h00);

    for (int i = 0; i < 3000; i++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      if (op == 3'd7 && ($urandom & 1)) op = 3'd1;
      step("R12", 1'($urandom), 1'($urandom), 1'($urandom), op, 8'($urandom));
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL R12 watchdog actual running expected finished");
      summary();
      $finish;
    end
  end
endmodule